// File: doc/BRIEF.md
# Masked-Update Temperature Result Register

This block holds the most recent digital temperature so that a host can fetch it over a serial bus. A converter delivers each finished measurement as a 12-bit signed sample together with a one-cycle done strobe. A 2-bit resolution select and a flag from the bus engine arrive alongside it. The flag is high while a read of the register is under way.

The block cuts each sample down to the selected precision and places it at the top of a 16-bit two's complement word, with zeros below. It then copies the word into the readable register, but only when no bus read is in progress. A sample that arrives during a read is dropped from the readable register. It is not held back for a later load. Every finished sample still goes to the thermal alarm logic, whatever the bus is doing. The alarm logic receives a one-cycle valid pulse and the cut-down value.

Top module: `temp_result_reg`

## Requirements
- R1: The output word is 16-bit two's complement. Sample bit 11 lands at word bit 15, which is the sign. Sample bit 10 lands at word bit 14, the temperature MSB. Sample bits 11..0 map to word bits 15..4, and word bits 3..0 are always zero.
- R2: Resolution select 0 keeps the top 9 word bits, 1 keeps 10, 2 keeps 11 and 3 keeps 12. Every word bit below the kept field is zero.
- R3: When `convDone` is high and `readBusy` is low at a rising clock edge, `tempWord` shows the truncated sample from the following cycle onward.
- R4: When `convDone` is high together with `readBusy`, `tempWord` keeps its previous value. That sample is never loaded later, and `tempWord` changes only on a later unmasked done strobe.
- R5: For every `convDone` strobe, whether `readBusy` is high or low, `alarmValid` is high for exactly the next cycle. In that cycle `alarmData` holds the truncated sample. `alarmValid` is low in every other cycle.
- R6: While `rstN` is low and after reset, `tempWord`, `alarmData` and `alarmValid` are zero until the first done strobe.
- R7: A change of `resSel` affects only samples taken at or after the change. The stored `tempWord` is never re-truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | One-cycle strobe: a conversion has finished |
| convData | input | 12 | Signed conversion sample |
| resSel | input | 2 | Resolution select (9 to 12 bits) |
| readBusy | input | 1 | High while the host is reading the register |
| tempWord | output | 16 | Readable temperature word |
| alarmValid | output | 1 | One-cycle pulse for each finished sample |
| alarmData | output | 16 | Truncated sample for the alarm logic |

## Verification
The bench targets four corner cases:
- A done strobe that coincides with a busy read. A design that deferred the sample instead of dropping it would load a stale value on the next idle cycle.
- A stream of back-to-back busy samples. A design that gated the alarm path with the bus flag would miss valid pulses there.
- A resolution change between samples. A design that masked the stored word live would alter `tempWord` with no new sample.
- The most negative and the all-ones samples at each of the four resolutions. These expose a wrong mask width or a lost sign bit.

// File: rtl/temp_result_pkg.sv
package temp_result_pkg;
  localparam int SAMPLE_W = 12;
  localparam int WORD_W   = 16;
  localparam int RES_W    = 2;
  localparam int MIN_RES  = 9;
  localparam int PAD_W    = WORD_W - SAMPLE_W;
  localparam int NUM_RES  = 1 << RES_W;

  typedef struct packed {
    logic loadReg;
    logic fwdSample;
  } ctrlStrobe_t;
endpackage

// File: rtl/temp_result_ctrl.sv
module temp_result_ctrl
  import temp_result_pkg::*;
(
  input  logic        convDone,
  input  logic        readBusy,
  output ctrlStrobe_t strobe
);
  // A read in progress masks only the readable register, never the alarm feed.
  always_comb begin
    strobe.fwdSample = convDone;
    strobe.loadReg   = convDone & ~readBusy;
  end
endmodule

// File: rtl/temp_result_dp.sv
module temp_result_dp
  import temp_result_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int WW = WORD_W,
  parameter int RW = RES_W,
  parameter int MR = MIN_RES
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [SW-1:0] sample,
  input  logic [RW-1:0] resSel,
  output logic [WW-1:0] tempWord,
  output logic          alarmValid,
  output logic [WW-1:0] alarmData
);
  localparam int NR = 1 << RW;
  localparam int PW = WW - SW;

  logic [WW-1:0] maskTable [NR];
  logic [WW-1:0] aligned;
  logic [WW-1:0] truncated;

  // One keep-mask per resolution setting: the top (MR + i) bits are set.
  for (genvar i = 0; i < NR; i++) begin : g_mask
    localparam int KEEP = MR + i;
    assign maskTable[i] = ~(WW'({WW{1'b1}}) >> KEEP);
  end

  assign aligned   = {sample, {PW{1'b0}}};
  assign truncated = aligned & maskTable[resSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempWord   <= '0;
      alarmValid <= 1'b0;
      alarmData  <= '0;
    end else begin
      alarmValid <= strobe.fwdSample;
      if (strobe.fwdSample) alarmData <= truncated;
      if (strobe.loadReg)   tempWord  <= truncated;
    end
  end
endmodule

// File: rtl/temp_result_reg.sv
module temp_result_reg
  import temp_result_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                convDone,
  input  logic [SAMPLE_W-1:0] convData,
  input  logic [RES_W-1:0]    resSel,
  input  logic                readBusy,
  output logic [WORD_W-1:0]   tempWord,
  output logic                alarmValid,
  output logic [WORD_W-1:0]   alarmData
);
  ctrlStrobe_t strobe;

  temp_result_ctrl u_ctrl (
    .convDone (convDone),
    .readBusy (readBusy),
    .strobe   (strobe)
  );

  temp_result_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sample     (convData),
    .resSel     (resSel),
    .tempWord   (tempWord),
    .alarmValid (alarmValid),
    .alarmData  (alarmData)
  );
endmodule

// File: rtl/temp_result_chk.sv
module temp_result_chk
  import temp_result_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                convDone,
  input logic [SAMPLE_W-1:0] convData,
  input logic [RES_W-1:0]    resSel,
  input logic                readBusy,
  input logic [WORD_W-1:0]   tempWord,
  input logic                alarmValid,
  input logic [WORD_W-1:0]   alarmData
);
  // R1 and R2: the four pad bits are never set.
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    tempWord[PAD_W-1:0] == '0);

  // R2: the sign and top 8 data bits of a forwarded sample follow the input.
  p_top_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> alarmData[WORD_W-1:WORD_W-MIN_RES] ==
                 $past(convData[SAMPLE_W-1:SAMPLE_W-MIN_RES]));

  // R3: an unmasked sample reaches the readable register.
  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !readBusy) |=> tempWord == alarmData);

  // R4: a masked sample leaves the register alone.
  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && readBusy) |=> $stable(tempWord));

  // R4 and R7: with no new sample, the register does not move.
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |=> $stable(tempWord));

  // R5: every sample produces a valid pulse, whatever the bus does.
  p_fwd_r5: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> alarmValid);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |=> !alarmValid);

  // R7: a resolution change alone does not alter the forwarded data.
  p_res_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!convDone && (resSel != $past(resSel))) |=> $stable(alarmData));
endmodule

bind temp_result_reg temp_result_chk u_chk (.*);

// File: tb/sim_temp_result_reg.sv
module sim_temp_result_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        convDone;
  logic [11:0] convData;
  logic [1:0]  resSel;
  logic        readBusy;
  logic [15:0] tempWord;
  logic        alarmValid;
  logic [15:0] alarmData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [15:0] expWord;
  logic [15:0] expAlarm;
  logic        expValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_result_reg u0 (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .resSel(resSel), .readBusy(readBusy), .tempWord(tempWord),
    .alarmValid(alarmValid), .alarmData(alarmData)
  );

  // R1, R2: the sample sits in bits 15..4; only the top (9 + res) bits are kept.
  function automatic logic [15:0] model(input logic [11:0] s, input logic [1:0] r);
    int keep = 9 + int'(r);
    logic [15:0] w = {s, 4'h0};
    for (int b = 0; b < 16; b++)
      if (b < 16 - keep) w[b] = 1'b0;
    return w;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Samples all outputs mid-cycle against the model state.
  task automatic checkAll(input string req);
    check({req, " tempWord"}, tempWord, expWord);
    check("R5 alarmValid", {15'h0, alarmValid}, {15'h0, expValid});
    if (expValid) check("R5 alarmData", alarmData, expAlarm);
  endtask

  // Drives one cycle at negedge, advances the model, then checks after the edge.
  task automatic step(input logic d, input logic [11:0] s, input logic [1:0] r,
                      input logic b, input string req);
    convDone = d; convData = s; resSel = r; readBusy = b;
    expValid = d;
    if (d) expAlarm = model(s, r);
    if (d && !b) expWord = model(s, r);
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    rstN = 1'b0; convDone = 1'b0; convData = '0; resSel = '0; readBusy = 1'b0;
    expWord = '0; expAlarm = '0; expValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 reset tempWord", tempWord, 16'h0);
    check("R6 reset alarmData", alarmData, 16'h0);
    check("R6 reset alarmValid", {15'h0, alarmValid}, 16'h0);
    rstN = 1'b1;
    step(1'b0, 12'hABC, 2'd3, 1'b0, "R6");

    // R1/R2: extreme codes at every resolution
    for (int r = 0; r < 4; r++) begin
      step(1'b1, 12'h800, 2'(r), 1'b0, "R2");
      step(1'b1, 12'hFFF, 2'(r), 1'b0, "R2");
      step(1'b1, 12'h7FF, 2'(r), 1'b0, "R1");
    end
    // R4: masked sample dropped, then idle cycles: no deferred load
    step(1'b1, 12'h123, 2'd3, 1'b0, "R3");
    step(1'b1, 12'h456, 2'd3, 1'b1, "R4");
    step(1'b0, 12'h456, 2'd3, 1'b0, "R4");
    step(1'b0, 12'h456, 2'd3, 1'b0, "R4");
    // R5: back-to-back busy samples still forwarded
    step(1'b1, 12'h111, 2'd2, 1'b1, "R5");
    step(1'b1, 12'h222, 2'd1, 1'b1, "R5");
    step(1'b1, 12'h333, 2'd0, 1'b0, "R3");
    // R7: resolution change without a sample keeps stored word
    step(1'b1, 12'hFFF, 2'd3, 1'b0, "R7");
    step(1'b0, 12'hFFF, 2'd0, 1'b0, "R7");
    step(1'b0, 12'h000, 2'd1, 1'b0, "R7");
    step(1'b1, 12'hFFF, 2'd0, 1'b0, "R7");

    // Constrained random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 2000; i++) begin
      logic d = ($urandom % 3) != 0;
      logic b = ($urandom % 2) != 0;
      step(d, 12'($urandom), 2'($urandom), b, "R3/R4");
    end

    // R6: reset mid-stream clears everything
    convDone = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R6 re-reset tempWord", tempWord, 16'h0);
    check("R6 re-reset alarmValid", {15'h0, alarmValid}, 16'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule